// File: doc/BRIEF.md
# Bus Error Interrupt Capture Register

This block is a 64-bit control and status word that records bus error events and raises a system-management interrupt. Seven single-cycle event strobes come in from the bus logic: target abort signaled, parity error, system error, exception marker in a response packet, SMI marker in a response packet, target abort received, and master abort received. Each event has a sticky flag and an enable bit in the same word.

An event sets its flag only while that event's enable bit is 1. With the enable at 0 the event is dropped, and it does not reach the interrupt either. Software reads the word through a simple select/write-enable port with a registered read path. It clears flags by writing 1s to them and changes the enables in the same write. The interrupt output stays high while any enabled flag is set.

Top module: `bus_err_capture`

## Requirements
- R1: After reset every bit of the word reads 0 and `irq_o` is 0.
- R2: When `event_i[n]` is 1 and enable bit n is 1 at a clock edge, flag bit 16+n is 1 after that edge. The events map from `event_i[6]` down to `event_i[0]` as: target abort signaled, parity error, system error, exception, SMI marker, target abort received, master abort received.
- R3: When the enable bit for an event is 0, a pulse on that event leaves its flag unchanged.
- R4: A write with bit 16+n at 1 clears flag n. A write with bit 16+n at 0 leaves flag n unchanged.
- R5: If an enabled event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R6: Enable bits 6:0 are plain read/write bits. Bit n holds the value last written to it.
- R7: Bits 63:23 and 15:7 always read 0, and writes to them have no effect.
- R8: `irq_o` is 1 exactly when at least one flag n is set and its enable bit n is also 1. It rises in the cycle after the enabled event.
- R9: A read (`sel_i`=1, `we_i`=0) puts the word as it stood at that edge on `rdata_o` one cycle later. `rdata_o` holds its value in cycles with no read.
- R10: With `sel_i` at 0, `we_i` and `wdata_i` have no effect on the enables or the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| we_i | input | 1 | Write when 1, read when 0 (qualified by sel_i) |
| wdata_i | input | 64 | Write data: enables in 6:0, clear mask in 22:16 |
| rdata_o | output | 64 | Registered read data |
| event_i | input | 7 | Single-cycle error event strobes |
| irq_o | output | 1 | System-management interrupt request |

## Verification
The hardest case to reach from the ports is an enabled event landing on a flag in the very cycle that a write-1 clear targets it. The write must also be changing the enables in that same cycle, so the bench has to show that gating uses the enable value held before the write. Directed steps set up this collision bit by bit. Random phases then drive frequent writes with random clear masks and enables against dense event strobes, so collisions and enable changes happen often. A bench model predicts every read and the interrupt level.

// File: rtl/bus_err_capture_pkg.sv
package bus_err_capture_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned EVENT_N  = 7;
  localparam int unsigned FLAG_POS = 16;
  localparam int unsigned EN_POS   = 0;
endpackage

// File: rtl/bus_err_capture_flag.sv
module bus_err_capture_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic en_i,
  input  logic clr_i,
  output logic flag_o
);
  logic set;
  assign set = event_i & en_i;

  // set has priority over clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/bus_err_capture_enable.sv
module bus_err_capture_enable #(
  parameter int unsigned EVENT_N = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [EVENT_N-1:0] wdata_i,
  output logic [EVENT_N-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (wr_i) en_o <= wdata_i;
  end
endmodule

// File: rtl/bus_err_capture_rdata.sv
module bus_err_capture_rdata #(
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned EVENT_N  = 7,
  parameter int unsigned FLAG_POS = 16,
  parameter int unsigned EN_POS   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [EVENT_N-1:0] flag_i,
  input  logic [EVENT_N-1:0] en_i,
  output logic [WORD_W-1:0]  rdata_o
);
  logic [WORD_W-1:0] word;

  // unmapped positions stay at zero
  always_comb begin
    word = '0;
    word[FLAG_POS +: EVENT_N] = flag_i;
    word[EN_POS   +: EVENT_N] = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= word;
  end
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bus_err_capture_pkg::*;
#(
  parameter int unsigned WORD_W_P   = WORD_W,
  parameter int unsigned EVENT_N_P  = EVENT_N,
  parameter int unsigned FLAG_POS_P = FLAG_POS,
  parameter int unsigned EN_POS_P   = EN_POS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [WORD_W_P-1:0]  wdata_i,
  output logic [WORD_W_P-1:0]  rdata_o,
  input  logic [EVENT_N_P-1:0] event_i,
  output logic                 irq_o
);
  logic                 wr, rd;
  logic [EVENT_N_P-1:0] en_q, flag_q, clr;

  assign wr  = sel_i & we_i;
  assign rd  = sel_i & ~we_i;
  assign clr = wr ? wdata_i[FLAG_POS_P +: EVENT_N_P] : '0;

  bus_err_capture_enable #(.EVENT_N(EVENT_N_P)) u_enable (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .wdata_i (wdata_i[EN_POS_P +: EVENT_N_P]),
    .en_o    (en_q)
  );

  for (genvar n = 0; n < EVENT_N_P; n++) begin : g_flag
    bus_err_capture_flag u_flag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .event_i (event_i[n]),
      .en_i    (en_q[n]),
      .clr_i   (clr[n]),
      .flag_o  (flag_q[n])
    );
  end

  bus_err_capture_rdata #(
    .WORD_W   (WORD_W_P),
    .EVENT_N  (EVENT_N_P),
    .FLAG_POS (FLAG_POS_P),
    .EN_POS   (EN_POS_P)
  ) u_rdata (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd),
    .flag_i  (flag_q),
    .en_i    (en_q),
    .rdata_o (rdata_o)
  );

  assign irq_o = |(flag_q & en_q);
endmodule

// File: rtl/bus_err_capture_chk.sv
module bus_err_capture_chk #(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned EVENT_N = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sel_i,
  input logic               we_i,
  input logic [WORD_W-1:0]  rdata_o,
  input logic [EVENT_N-1:0] event_i,
  input logic               irq_o,
  input logic [EVENT_N-1:0] flag_q,
  input logic [EVENT_N-1:0] en_q
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[63:23] == '0 && rdata_o[15:7] == '0); // R7

  AST_ENABLED_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(event_i & en_q)) == $past(event_i & en_q))); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(event_i & en_q)) == '0)); // R3

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|(event_i & en_q)) || $past(sel_i && we_i))); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !we_i) |=> $stable(rdata_o)); // R9

  AST_NO_SEL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(en_q)); // R10
endmodule

bind bus_err_capture bus_err_capture_chk #(
  .WORD_W  (WORD_W_P),
  .EVENT_N (EVENT_N_P)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .we_i    (we_i),
  .rdata_o (rdata_o),
  .event_i (event_i),
  .irq_o   (irq_o),
  .flag_q  (flag_q),
  .en_q    (en_q)
);

// File: tb/bus_err_capture_bench.sv
`timescale 1ns/1ps
module bus_err_capture_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic [6:0]  event_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [6:0]  m_flag = '0, m_en = '0;
  logic [63:0] m_rdata = '0;

  always #2.5 clk_i = ~clk_i;

  bus_err_capture u_bus_err_capture (
    .clk_i, .rst_ni, .sel_i, .we_i, .wdata_i, .rdata_o, .event_i, .irq_o
  );

  function automatic logic [63:0] word_of(logic [6:0] f, logic [6:0] e);
    logic [63:0] w = '0;
    w[22:16] = f;
    w[6:0]   = e;
    return w;
  endfunction

  function automatic logic [6:0] next_flag(logic [6:0] f, logic [6:0] e,
      logic s, logic w, logic [63:0] d, logic [6:0] ev);
    logic [6:0] c = (s && w) ? d[22:16] : 7'h00;
    return (f & ~c) | (ev & e);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, clock, update model, compare irq and rdata
  task automatic step(logic s, logic w, logic [63:0] d, logic [6:0] ev, string req);
    logic [6:0] nf;
    sel_i = s; we_i = w; wdata_i = d; event_i = ev;
    nf = next_flag(m_flag, m_en, s, w, d, ev);
    if (s && !w) m_rdata = word_of(m_flag, m_en);
    @(posedge clk_i); #1;
    m_flag = nf;
    if (s && w) m_en = d[6:0];
    sel_i = 1'b0; we_i = 1'b0; event_i = '0;
    chk({req, " irq R8"}, {63'b0, irq_o}, {63'b0, |(m_flag & m_en)});
    chk({req, " rdata R9"}, rdata_o, m_rdata);
  endtask

  task automatic rd(string req);
    step(1'b1, 1'b0, $urandom, 7'h00, req);
    chk({req, " word"}, rdata_o, word_of(m_flag, m_en));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    chk("R1 rdata", rdata_o, 64'h0);
    chk("R1 irq", {63'b0, irq_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd("R1");

    // R6 R7: enables written, reserved bits ignored
    step(1'b1, 1'b1, 64'hFFFF_FF80_0000_FF55, 7'h00, "R7");
    rd("R6 R7");
    step(1'b1, 1'b1, 64'hFFFF_FF80_0000_FF7F, 7'h00, "R6");
    rd("R6");

    // R2: each event sets its own flag
    for (int n = 0; n < 7; n++) begin
      step(1'b0, 1'b0, '0, 7'(1 << n), "R2");
      rd("R2");
    end

    // R4: write 0 keeps, write 1 clears
    step(1'b1, 1'b1, 64'h0000_0000_0000_007F, 7'h00, "R4 zero");
    rd("R4 zero");
    step(1'b1, 1'b1, 64'h0000_0000_0005_007F, 7'h00, "R4 one");
    rd("R4 one");

    // R5: set and clear on the same flag, while enables are turned off
    for (int n = 0; n < 7; n++) begin
      step(1'b1, 1'b1, 64'h0000_0000_0000_007F | (64'h1 << (16 + n)), 7'(1 << n), "R5");
      rd("R5");
    end
    step(1'b1, 1'b1, 64'h0000_0000_0000_0000 | (64'h7F << 16), 7'h7F, "R5 gate");
    rd("R5 gate");

    // R3: disabled events ignored
    step(1'b1, 1'b1, 64'h0000_0000_007F_0000, 7'h00, "R3 clr");
    step(1'b0, 1'b0, '0, 7'h7F, "R3");
    rd("R3");
    chk("R3 irq", {63'b0, irq_o}, 64'h0);

    // R10: no select, no write
    step(1'b0, 1'b1, 64'h0000_0000_0000_007F, 7'h00, "R10");
    rd("R10");

    // R9: rdata held without a read
    step(1'b1, 1'b1, 64'h0000_0000_0000_0011, 7'h00, "R9 wr");
    step(1'b0, 1'b0, '0, 7'h11, "R9 hold");
    step(1'b1, 1'b1, 64'h0000_0000_0000_0033, 7'h00, "R9 hold");
    rd("R9");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic s = ($urandom_range(0, 3) != 0);
      logic w = $urandom_range(0, 1);
      logic [63:0] d = {$urandom, $urandom};
      logic [6:0] ev = 7'($urandom) & 7'($urandom);
      step(s, w, d, ev, "RND");
    end
    rd("RND final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule